// File: doc/BRIEF.md
# Radix-3 Partition Constant Multiplier

This block multiplies an unsigned 8-bit sample by one fixed, signed 16-bit fixed-point coefficient, and it does so without a multiplier. The sample is first rewritten as six signed digits, each in {-1, 0, +1}. Each digit weights one part of a fixed partition of 255. Five of the parts are the powers of three from 1 to 81. The sixth is a remainder part, 134, which makes the parts add up to exactly 255.

Each part times the coefficient is a constant worked out at elaboration time. The product is then built by adding, subtracting or skipping each of those constants, as the matching digit says. A balanced binary adder tree does the combining. Both the digit code and the product come out, so a neighbour that shares the code across several coefficients can reuse it.

The block has two pipeline stages. The digit code is registered in the first stage and the product in the second. A valid flag travels with the data.

Top module: `tern_cmul`

## Requirements
- R1: The parts, in digit order from index 0 to index 5, are 1, 3, 9, 27, 81 and 134. Digit k is held in outCode bits [2k+1:2k]. The digit encoding is 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1.
- R2: For every input from 0 to 255, the sum over k of digit k times part k equals the input exactly.
- R3: For an input of 121 or less, digit 5 (part 134) is 0 and the input is written in balanced ternary over the five powers of three. For an input above 121, digit 5 is +1 and (input - 134) is written in balanced ternary. Examples: 121 gives outCode 12'h155, 122 gives 12'h43C and 255 gives 12'h555.
- R4: Input 23 gives the digits -1, -1, 0, +1, 0, 0 for parts 1, 3, 9, 27, 81, 134, which is outCode 12'h04F.
- R5: For every input x, outProd equals x times COEF as an exact signed 24-bit two's-complement value.
- R6: outValid is high exactly two clock cycles after inValid was high. outCode and outProd in that cycle belong to the sample accepted two cycles earlier.
- R7: A sample presented while inValid is low has no effect. After an invalid input, outCode and outProd keep their previous values.
- R8: While reset is asserted (rst_n low), outValid, outCode and outProd are all zero.
- R9: No digit of outCode ever holds the unused pattern 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks inSample as a sample to process |
| inSample | input | 8 | Unsigned input sample |
| outValid | output | 1 | Marks outCode and outProd as valid |
| outCode | output | 12 | Six two-bit signed digits, digit k at bits [2k+1:2k] |
| outProd | output | 24 | Signed product of the sample and the coefficient |

## Verification
The bench concentrates on the seam at 121/122, where the remainder digit switches on. An encoder that picks the wrong threshold would produce a code that still decodes but does not match the stated pattern. At 122, (input - 134) is negative, so a modulo that mishandles negative values would give a wrong reconstruction. The bench also checks the 23, 134 and 255 patterns, and every input against an exact multiplication by a negative coefficient; a sign-extension or subtract-path error shows up there as a wrong product. Finally, a lone valid followed by invalid inputs carrying new data exposes any latency that is off by one, and any register that loads without its strobe.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  // Two-bit signed digit encoding
  localparam logic [1:0] DIG_ZERO = 2'b00;
  localparam logic [1:0] DIG_POS  = 2'b01;
  localparam logic [1:0] DIG_NEG  = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEnc;  // capture the digit code of the incoming sample
    logic loadOut;  // capture the summed product
  } tcm_strobe_t;

  function automatic int pow3(input int k);
    int p;
    p = 1;
    for (int i = 0; i < k; i++) p = p * 3;
    return p;
  endfunction

  // Count of parts: the number of powers of three not above 2*top
  function automatic int numParts(input int inW);
    int top;
    int p;
    int n;
    top = (1 << inW) - 1;
    p = 1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (p <= 2 * top) begin
        n = n + 1;
        p = p * 3;
      end
    end
    return n;
  endfunction

  // Part k: a power of three, or the remainder for the last index
  function automatic int partValue(input int inW, input int k);
    int np;
    np = numParts(inW);
    if (k < np - 1) return pow3(k);
    return ((1 << inW) - 1) - (pow3(np - 1) - 1) / 2;
  endfunction

endpackage

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output tcm_strobe_t strobe,
  output logic        outValid
);

  logic stage1Valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobe.loadEnc = inValid;
    strobe.loadOut = stage1Valid;
  end

  // R6: a valid sample appears at the output two cycles later
  p_latency_on_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ##2 outValid);

  // R6: no output valid without a sample two cycles earlier
  p_latency_off_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |-> ##2 !outValid);

endmodule

// File: rtl/tcm_datapath.sv
module tcm_datapath
  import tcm_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int COEF  = 23170,
  parameter int NP    = 6,
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tcm_strobe_t             strobe,
  input  logic [IN_W-1:0]         inSample,
  output logic [2*NP-1:0]         outCode,
  output logic signed [OUT_W-1:0] outProd
);

  localparam int HALF   = (pow3(NP - 1) - 1) / 2;
  localparam int PART_R = partValue(IN_W, NP - 1);
  localparam int DEPTH  = $clog2(NP);
  localparam int LEAVES = 1 << DEPTH;

  logic [2*NP-1:0] encCode;
  logic [2*NP-1:0] codeQ;

  // Balanced-ternary encoder over the partition
  always_comb begin : enc
    int v;
    int m;
    encCode = '0;
    v = int'(inSample);
    if (v > HALF) begin
      encCode[2*NP-1 -: 2] = DIG_POS;
      v = v - PART_R;
    end
    for (int k = 0; k < NP - 1; k++) begin
      m = v % 3;
      if (m < 0) m = m + 3;
      if (m == 1) begin
        encCode[2*k +: 2] = DIG_POS;
        v = (v - 1) / 3;
      end else if (m == 2) begin
        encCode[2*k +: 2] = DIG_NEG;
        v = (v + 1) / 3;
      end else begin
        v = v / 3;
      end
    end
  end

  // Stage 1: digit code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) codeQ <= '0;
    else if (strobe.loadEnc) codeQ <= encCode;
  end

  // Adder tree over the signed constant terms
  for (genvar l = 0; l <= DEPTH; l++) begin : lvl
    localparam int W = LEAVES >> l;
    logic signed [OUT_W-1:0] sum [W];
    if (l == 0) begin : leafs
      for (genvar k = 0; k < LEAVES; k++) begin : lf
        if (k < NP) begin : used
          localparam logic signed [OUT_W-1:0] TERM = OUT_W'(partValue(IN_W, k) * COEF);
          always_comb begin
            case (codeQ[2*k +: 2])
              DIG_POS: sum[k] = TERM;
              DIG_NEG: sum[k] = -TERM;
              default: sum[k] = '0;
            endcase
          end
        end else begin : pad
          assign sum[k] = '0;
        end
      end
    end else begin : adds
      for (genvar j = 0; j < W; j++) begin : ad
        assign sum[j] = lvl[l-1].sum[2*j] + lvl[l-1].sum[2*j+1];
      end
    end
  end

  // Stage 2: product and aligned code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outCode <= '0;
      outProd <= '0;
    end else if (strobe.loadOut) begin
      outCode <= codeQ;
      outProd <= lvl[DEPTH].sum[0];
    end
  end

  // Checker helpers
  function automatic int decodeSum(input logic [2*NP-1:0] c);
    int s;
    s = 0;
    for (int k = 0; k < NP; k++) begin
      if (c[2*k +: 2] == DIG_POS) s = s + partValue(IN_W, k);
      else if (c[2*k +: 2] == DIG_NEG) s = s - partValue(IN_W, k);
    end
    return s;
  endfunction

  function automatic logic codeLegal(input logic [2*NP-1:0] c);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NP; k++) if (c[2*k +: 2] == 2'b10) ok = 1'b0;
    return ok;
  endfunction

  // R9: no unused digit pattern reaches the outputs
  p_legal_digits_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    codeLegal(outCode) && codeLegal(codeQ));

  // R3: remainder digit follows the threshold
  p_top_digit_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadEnc |=> (codeQ[2*NP-1 -: 2] ==
      ((int'($past(inSample)) > HALF) ? DIG_POS : DIG_ZERO)));

  // R2: the stored digits rebuild the accepted sample
  p_reconstruct_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadEnc |=> (decodeSum(codeQ) == int'($past(inSample))));

  // R5: tree result matches the code times the coefficient
  p_product_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadOut |=> (int'(outProd) == decodeSum(outCode) * COEF));

  // R7: outputs hold without a load strobe
  p_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadOut |=> ($stable(outProd) && $stable(outCode)));

endmodule

// File: rtl/tern_cmul.sv
module tern_cmul
  import tcm_pkg::*;
#(
  parameter  int IN_W   = 8,
  parameter  int COEF_W = 16,
  parameter  int COEF   = 23170,
  localparam int NP     = numParts(IN_W),
  localparam int OUT_W  = COEF_W + IN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic [IN_W-1:0]         inSample,
  output logic                    outValid,
  output logic [2*NP-1:0]         outCode,
  output logic signed [OUT_W-1:0] outProd
);

  tcm_strobe_t strobe;

  tcm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  tcm_datapath #(
    .IN_W  (IN_W),
    .COEF  (COEF),
    .NP    (NP),
    .OUT_W (OUT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inSample (inSample),
    .outCode  (outCode),
    .outProd  (outProd)
  );

endmodule

// File: tb/tern_cmul_bench.sv
module tern_cmul_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BCOEF = -32749;
  localparam int PARTS [6] = '{1, 3, 9, 27, 81, 134};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               inValid = 1'b0;
  logic [7:0]         inSample = '0;
  logic               outValid;
  logic [11:0]        outCode;
  logic signed [23:0] outProd;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  tern_cmul #(.COEF(BCOEF)) u_tern_cmul (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inSample (inSample),
    .outValid (outValid),
    .outCode  (outCode),
    .outProd  (outProd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int digitOf(input logic [11:0] c, input int k);
    case (c[2*k +: 2])
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return -1;
      default: return 99;
    endcase
  endfunction

  function automatic int rebuild(input logic [11:0] c);
    int s;
    s = 0;
    for (int k = 0; k < 6; k++) s = s + digitOf(c, k) * PARTS[k];
    return s;
  endfunction

  function automatic int badDigits(input logic [11:0] c);
    int n;
    n = 0;
    for (int k = 0; k < 6; k++) if (c[2*k +: 2] == 2'b10) n++;
    return n;
  endfunction

  // Drive one sample, then idle; result read two cycles after the driving edge
  task automatic single(input int x, output logic [11:0] code, output int prod);
    @(negedge clk);
    inSample = 8'(x);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    code = outCode;
    prod = int'(outProd);
  endtask

  task automatic testReset;
    chk("R8 outValid in reset", int'(outValid), 0);
    chk("R8 outCode in reset", int'(outCode), 0);
    chk("R8 outProd in reset", int'(outProd), 0);
  endtask

  task automatic testSweep;
    for (int c = 0; c < 258; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        chk("R6 outValid during stream", int'(outValid), 1);
        chk("R2 rebuild", rebuild(outCode), c - 2);
        chk("R9 legal digits", badDigits(outCode), 0);
        chk("R3 top digit", digitOf(outCode, 5), (c - 2 > 121) ? 1 : 0);
        chk("R5 product", int'(outProd), (c - 2) * BCOEF);
      end
      if (c < 256) begin
        inSample = 8'(c);
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testPatterns;
    logic [11:0] code;
    int prod;
    single(23, code, prod);
    chk("R4 code of 23", int'(code), 12'h04F);
    chk("R5 product of 23", prod, 23 * BCOEF);
    single(134, code, prod);
    chk("R1 code of 134", int'(code), 12'h400);
    single(121, code, prod);
    chk("R3 code of 121", int'(code), 12'h155);
    single(122, code, prod);
    chk("R3 code of 122", int'(code), 12'h43C);
    chk("R5 product of 122", prod, 122 * BCOEF);
    single(255, code, prod);
    chk("R3 code of 255", int'(code), 12'h555);
    chk("R5 product of 255", prod, 255 * BCOEF);
    single(0, code, prod);
    chk("R1 code of 0", int'(code), 0);
    chk("R5 product of 0", prod, 0);
  endtask

  task automatic testGapHold;
    @(negedge clk);
    inSample = 8'd200;
    inValid = 1'b1;
    @(negedge clk);
    inSample = 8'd7;
    inValid = 1'b0;
    chk("R6 not yet valid", int'(outValid), 0);
    @(negedge clk);
    inSample = 8'd99;
    chk("R6 valid after two cycles", int'(outValid), 1);
    chk("R6 product aligned", int'(outProd), 200 * BCOEF);
    @(negedge clk);
    inSample = 8'd150;
    chk("R6 single valid pulse", int'(outValid), 0);
    chk("R7 product held", int'(outProd), 200 * BCOEF);
    chk("R7 code held", rebuild(outCode), 200);
    @(negedge clk);
    @(negedge clk);
    chk("R7 product still held", int'(outProd), 200 * BCOEF);
    chk("R7 valid stays low", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset;
    rst_n = 1'b1;
    @(negedge clk);
    testSweep;
    testPatterns;
    testGapHold;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule